// File: doc/BRIEF.md
# Program Flow Trace Recorder

This block captures the program flow of a processor for an on-chip debugger. Each time the processor reports a control-flow change (a call, a return, an interrupt entry or return, a trap, a jump, a decrement-and-branch, or an exception), the recorder writes two 32-bit words to a trace memory. The first word is the program counter before the change and the second is the program counter after it. Only these two values are stored.

Software programs a start pointer and a control register on a small register bus. The pointer walks through a power-of-two window whose base is aligned to the window size. When the pointer passes the top of the window it returns to the window base, so the memory holds a rolling history of the most recent events. The memory itself, read-out of the trace and the debugger software are outside this block.

While an event is being recorded, the recorder raises `busy`. The processor holds any further event until `busy` is low again.

Top module: `flow_trace_recorder`

## Requirements
- R1: The control register resets to 00H. Bit 7 is the trace enable and bits 2:0 are the window select. Writes keep only those four bits, so all other bits read back as zero on `ctlValue`.
- R2: An accepted event produces exactly two memory writes, each with `memWe` high for one cycle. In the first cycle after acceptance, `curPc` is written at the pointer. In the second cycle, `nextPc` is written at the advanced pointer.
- R3: While bit 7 of the control register is zero, event strobes are ignored: `busy` stays low, `memWe` stays low and the pointer keeps its value.
- R4: The pointer resets to zero. A write to the address register loads the written value with bits 1:0 forced to zero, and every trace write address is word aligned.
- R5: `busy` rises in the cycle after acceptance. It stays high for 4 cycles for event codes 0 (call), 1 (return), 3 (interrupt return), 5 (jump) and 6 (decrement-and-branch). It stays high for 5 cycles for codes 2 (interrupt), 4 (trap) and 7 (exception).
- R6: The window is 128 shifted left by the select value, in bytes, and its base is aligned to its size. Each advance adds 4 inside the window only. Address bits above the window never change, and the offset rolls from the top of the window back to zero.
- R7: `addrValue` always shows the live pointer. After an event it equals the start pointer plus 8, wrapped within the window.
- R8: An event is accepted only in a cycle with `busy` low. A strobe that is held through a busy period is accepted in the first cycle `busy` is low, so no event is lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the address register |
| regWrData | input | 32 | Register write data |
| ctlValue | output | 8 | Control register contents |
| addrValue | output | 32 | Live trace pointer |
| evtValid | input | 1 | Control-flow event strobe |
| evtKind | input | 3 | Event code (see R5) |
| curPc | input | 32 | Program counter before the event |
| nextPc | input | 32 | Program counter after the event |
| busy | output | 1 | Event being recorded; hold further events |
| memWe | output | 1 | Trace memory write strobe |
| memAddr | output | 32 | Trace memory byte address |
| memData | output | 32 | Trace memory write data |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 3-bit window select and a 128-byte smallest window. With these values every window from 128 bytes to 16 KiB can be selected at run time. This makes the roll-over at the top of the smallest, a middle and the largest window reachable in a few cycles each, including a roll that falls between the two words of one event. The defaults also cover the short and long event classes and a strobe held across a busy period.

// File: rtl/ftr_pkg.sv
`timescale 1ns/1ps
package ftr_pkg;

  typedef enum logic [2:0] {
    EV_CALL = 3'd0,
    EV_RET  = 3'd1,
    EV_IRQ  = 3'd2,
    EV_IRET = 3'd3,
    EV_TRAP = 3'd4,
    EV_JUMP = 3'd5,
    EV_LOOP = 3'd6,
    EV_EXC  = 3'd7
  } evKind_e;

  typedef struct packed {
    logic capture;
    logic writeCur;
    logic writeNext;
  } trStrobe_t;

  function automatic logic isLongEvent(evKind_e k);
    return (k == EV_IRQ) || (k == EV_TRAP) || (k == EV_EXC);
  endfunction

endpackage

// File: rtl/ftr_ctrl.sv
`timescale 1ns/1ps
module ftr_ctrl
  import ftr_pkg::*;
#(
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       evtValid,
  input  logic [2:0] evtKind,
  output logic       busy,
  output trStrobe_t  strobe
);

  localparam int CNT_W = $clog2(LONG_LEN + 1);

  logic             busyQ;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] lastPhase;
  logic             accept;

  assign accept = evtValid && enable && !busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      phaseCnt  <= '0;
      lastPhase <= '0;
    end else if (accept) begin
      busyQ     <= 1'b1;
      phaseCnt  <= '0;
      lastPhase <= isLongEvent(evKind_e'(evtKind)) ? CNT_W'(LONG_LEN - 1)
                                                   : CNT_W'(SHORT_LEN - 1);
    end else if (busyQ) begin
      if (phaseCnt == lastPhase) begin
        busyQ <= 1'b0;
      end
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe.capture   = accept;
    strobe.writeCur  = busyQ && (phaseCnt == CNT_W'(0));
    strobe.writeNext = busyQ && (phaseCnt == CNT_W'(1));
  end

  assign busy = busyQ;

endmodule

// File: rtl/ftr_datapath.sv
`timescale 1ns/1ps
module ftr_datapath
  import ftr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 7,
  parameter int CTL_W     = 8,
  parameter int EN_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  trStrobe_t         strobe,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  output logic              enable,
  output logic [CTL_W-1:0]  ctlValue,
  output logic [ADDR_W-1:0] addrValue,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memData
);

  localparam int WORD_BYTES = 4;
  localparam int ALIGN_W    = $clog2(WORD_BYTES);
  localparam logic [CTL_W-1:0] CTL_KEEP =
      (CTL_W'(1) << EN_BIT) | CTL_W'((1 << SEL_W) - 1);

  logic [CTL_W-1:0]  ctlQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] curQ;
  logic [ADDR_W-1:0] nextQ;
  logic [SEL_W-1:0]  winSel;
  logic [ADDR_W-1:0] winMask;
  logic [ADDR_W-1:0] ptrInc;
  logic [ADDR_W-1:0] ptrWrap;

  assign winSel  = ctlQ[SEL_W-1:0];
  assign winMask = ((ADDR_W'(1) << BASE_LOG2) << winSel) - ADDR_W'(1);
  assign ptrInc  = ptrQ + ADDR_W'(WORD_BYTES);
  assign ptrWrap = (ptrQ & ~winMask) | (ptrInc & winMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (regWrEn && !regSel) begin
      ctlQ <= regWrData[CTL_W-1:0] & CTL_KEEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (regWrEn && regSel) begin
      ptrQ <= {regWrData[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else if (memWe) begin
      ptrQ <= ptrWrap;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ  <= '0;
      nextQ <= '0;
    end else if (strobe.capture) begin
      curQ  <= curPc;
      nextQ <= nextPc;
    end
  end

  assign memWe     = strobe.writeCur || strobe.writeNext;
  assign memAddr   = ptrQ;
  assign memData   = strobe.writeNext ? nextQ : curQ;
  assign enable    = ctlQ[EN_BIT];
  assign ctlValue  = ctlQ;
  assign addrValue = ptrQ;

endmodule

// File: rtl/flow_trace_recorder.sv
`timescale 1ns/1ps
module flow_trace_recorder
  import ftr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 7,
  parameter int SHORT_LEN = 4,
  parameter int LONG_LEN  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [7:0]        ctlValue,
  output logic [ADDR_W-1:0] addrValue,
  input  logic              evtValid,
  input  logic [2:0]        evtKind,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memData
);

  trStrobe_t strobe;
  logic      enable;

  ftr_ctrl #(
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .evtValid(evtValid),
    .evtKind (evtKind),
    .busy    (busy),
    .strobe  (strobe)
  );

  ftr_datapath #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .BASE_LOG2(BASE_LOG2),
    .CTL_W    (8),
    .EN_BIT   (7)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .regWrData(regWrData),
    .strobe   (strobe),
    .curPc    (curPc),
    .nextPc   (nextPc),
    .enable   (enable),
    .ctlValue (ctlValue),
    .addrValue(addrValue),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memData  (memData)
  );

endmodule

// File: rtl/ftr_checker.sv
`timescale 1ns/1ps
module ftr_checker #(
  parameter int ADDR_W    = 32,
  parameter int BASE_LOG2 = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [7:0]        ctlValue,
  input logic [ADDR_W-1:0] addrValue,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);

  logic [3:0]        runLen;
  logic [3:0]        runWrites;
  logic [ADDR_W-1:0] winMask;

  assign winMask = ((ADDR_W'(1) << BASE_LOG2) << ctlValue[2:0]) - ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || !busy) begin
      runLen    <= '0;
      runWrites <= '0;
    end else begin
      runLen    <= runLen + 4'd1;
      runWrites <= runWrites + {3'd0, memWe};
    end
  end

  a_r4_aligned_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[1:0] == 2'b00));

  a_r2_two_writes: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runWrites == 4'd2));

  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == 4'd4 || runLen == 4'd5));

  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlValue[7] && !busy) |=> !busy);

  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !regWrEn) |=>
      ((addrValue & ~winMask) == ($past(addrValue) & ~winMask)));

  a_r2_write_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

endmodule

bind flow_trace_recorder ftr_checker #(
  .ADDR_W   (ADDR_W),
  .BASE_LOG2(BASE_LOG2)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .ctlValue (ctlValue),
  .addrValue(addrValue),
  .busy     (busy),
  .memWe    (memWe),
  .memAddr  (memAddr)
);

// File: tb/flow_trace_recorder_test.sv
`timescale 1ns/1ps
module flow_trace_recorder_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic        regSel;
  logic [31:0] regWrData;
  logic [7:0]  ctlValue;
  logic [31:0] addrValue;
  logic        evtValid;
  logic [2:0]  evtKind;
  logic [31:0] curPc;
  logic [31:0] nextPc;
  logic        busy;
  logic        memWe;
  logic [31:0] memAddr;
  logic [31:0] memData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flow_trace_recorder uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ctlValue(ctlValue), .addrValue(addrValue),
    .evtValid(evtValid), .evtKind(evtKind), .curPc(curPc), .nextPc(nextPc),
    .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic [31:0] start;
    logic [2:0]  kind;
    logic [31:0] addr1;
    logic [31:0] addr2;
    logic [31:0] ptrAfter;
    logic [3:0]  len;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h81, 32'hFFFFB050, 3'd0, 32'hFFFFB050, 32'hFFFFB054, 32'hFFFFB058, 4'd4},
    '{8'h81, 32'hFFFFB0F8, 3'd2, 32'hFFFFB0F8, 32'hFFFFB0FC, 32'hFFFFB000, 4'd5},
    '{8'h81, 32'hFFFFB0FC, 3'd4, 32'hFFFFB0FC, 32'hFFFFB000, 32'hFFFFB004, 4'd5},
    '{8'h80, 32'h0000207C, 3'd1, 32'h0000207C, 32'h00002000, 32'h00002004, 4'd4},
    '{8'h87, 32'h12347FF8, 3'd7, 32'h12347FF8, 32'h12347FFC, 32'h12344000, 4'd5},
    '{8'h83, 32'h00000403, 3'd6, 32'h00000400, 32'h00000404, 32'h00000408, 4'd4},
    '{8'h82, 32'hABCD01FC, 3'd3, 32'hABCD01FC, 32'hABCD0000, 32'hABCD0004, 4'd4},
    '{8'h81, 32'h00000050, 3'd5, 32'h00000050, 32'h00000054, 32'h00000058, 4'd4}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runEvent(input logic [2:0] kind, input logic [31:0] cur,
                          input logic [31:0] nxt,
                          output logic [31:0] a1, output logic [31:0] d1,
                          output logic [31:0] a2, output logic [31:0] d2,
                          output int nWe, output int len);
    a1 = '0; d1 = '0; a2 = '0; d2 = '0; nWe = 0; len = 0;
    @(negedge clk);
    evtValid = 1'b1; evtKind = kind; curPc = cur; nextPc = nxt;
    @(negedge clk);
    evtValid = 1'b0;
    for (int k = 0; k < 12 && busy; k++) begin
      len++;
      if (memWe) begin
        if (nWe == 0) begin a1 = memAddr; d1 = memData; end
        else begin a2 = memAddr; d2 = memData; end
        nWe++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a1, d1, a2, d2, cur, nxt;
    int nWe, len, seen;
    logic [31:0] wAddr [4];
    rstN = 1'b0; regWrEn = 1'b0; regSel = 1'b0; regWrData = '0;
    evtValid = 1'b0; evtKind = '0; curPc = '0; nextPc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state: R1, R4, R5
    check("R1", "reset ctlValue", {24'd0, ctlValue}, 32'h0);
    check("R4", "reset addrValue", addrValue, 32'h0);
    check("R5", "reset busy", {31'd0, busy}, 32'h0);
    check("R2", "reset memWe", {31'd0, memWe}, 32'h0);

    // Table-driven events
    for (int i = 0; i < 8; i++) begin
      cur = 32'h1000_0000 + 32'(i * 16);
      nxt = cur ^ 32'h00FF_0000;
      regWrite(1'b0, {24'd0, VECS[i].ctl});
      regWrite(1'b1, VECS[i].start);
      runEvent(VECS[i].kind, cur, nxt, a1, d1, a2, d2, nWe, len);
      check("R2", "write count", 32'(nWe), 32'd2);
      check("R4", "first address", a1, VECS[i].addr1);
      check("R2", "first data", d1, cur);
      check("R6", "second address", a2, VECS[i].addr2);
      check("R2", "second data", d2, nxt);
      check("R5", "busy length", 32'(len), {28'd0, VECS[i].len});
      check("R7", "pointer after", addrValue, VECS[i].ptrAfter);
    end

    // R1: bits outside enable and select read back as zero
    regWrite(1'b0, 32'hFFFF_FFFF);
    check("R1", "masked control", {24'd0, ctlValue}, 32'h87);

    // R3: disabled, strobes ignored
    regWrite(1'b0, 32'h01);
    regWrite(1'b1, 32'h0000_0100);
    @(negedge clk);
    evtValid = 1'b1; evtKind = 3'd0; curPc = 32'h1; nextPc = 32'h2;
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (busy || memWe) seen++;
    end
    evtValid = 1'b0;
    check("R3", "activity while disabled", 32'(seen), 32'd0);
    check("R3", "pointer kept", addrValue, 32'h0000_0100);

    // R8: strobe held through a busy period, two events back to back
    regWrite(1'b0, 32'h80);
    regWrite(1'b1, 32'h0000_3078);
    @(negedge clk);
    evtValid = 1'b1; evtKind = 3'd5; curPc = 32'hA0; nextPc = 32'hA4;
    seen = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) begin curPc = 32'hB0; nextPc = 32'hB4; end
      if (k == 6) evtValid = 1'b0;
      if (k == 5) check("R8", "gap cycle busy", {31'd0, busy}, 32'h0);
      if (memWe) begin
        if (seen < 4) wAddr[seen] = memAddr;
        seen++;
      end
    end
    check("R8", "writes for two events", 32'(seen), 32'd4);
    check("R8", "third address", wAddr[2], 32'h0000_3000);
    check("R8", "fourth address", wAddr[3], 32'h0000_3004);
    check("R7", "pointer after pair", addrValue, 32'h0000_3008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule